// File: doc/BRIEF.md
# Edge-Triggered Timer Capture Channel

This block takes a snapshot of a free-running timer whenever a chosen transition appears on an external input. The input is asynchronous, so it first crosses into the clock domain through two flops. A history flop then turns it into single-cycle rise and fall events. A two-bit mode field picks which events count: rising only, falling only, both, or none.

Each accepted event stores the timer value from the cycle the event is seen, in a small first-in first-out store. Software reads the stored values later, oldest first, through a head-of-queue output and a pop strobe. Each stored value raises an interrupt pulse for one cycle. If an event arrives while the store is full, the value is discarded and a sticky overflow flag is set. Software clears that flag through a separate strobe. Dropping the enable empties the store, clears the overflow flag and forgets the last sampled pin level.

Top module: `edge_capture_fifo`

## Requirements
- R1: The pin passes through two synchronizer flops. A pin level applied before clock edge k is stored at edge k+2, together with the timer value present in the cycle just before edge k+2.
- R2: With `edge_mode` = 2'b01, a 0-to-1 transition is captured and a 1-to-0 transition is not.
- R3: With `edge_mode` = 2'b10, a 1-to-0 transition is captured and a 0-to-1 transition is not.
- R4: With `edge_mode` = 2'b11, both transitions are captured.
- R5: With `edge_mode` = 2'b00, no transition is captured.
- R6: Stored values are presented on `head_data` in arrival order. `head_data` is meaningful only while `not_empty` is 1.
- R7: The store holds DEPTH entries (default 4). A capture into a full store that is not being popped in the same cycle is discarded, leaves the contents unchanged and sets `overflow`.
- R8: `overflow` stays set until a cycle with `ovf_clr` = 1. If a discard happens in the same cycle as `ovf_clr`, the discard wins.
- R9: A pop on an empty store has no effect. A capture and a pop in the same cycle both take effect, and this includes the case where the store is full, where no overflow occurs.
- R10: `cap_irq` is high for exactly one cycle after each stored capture, aligned with the edge that stores it. A discarded capture gives no pulse.
- R11: While `enable` is 0, the store is empty, `overflow` is 0 and nothing is captured. In the first enabled cycle the current pin level becomes the reference, so a level change made while disabled is not captured.
- R12: After reset, `not_empty`, `overflow` and `cap_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 1 | Asynchronous event input |
| timer_val | input | TW (16) | Free-running timer value |
| edge_mode | input | 2 | 01 rising, 10 falling, 11 both, 00 none |
| enable | input | 1 | Channel enable; low flushes the channel |
| rd_pop | input | 1 | Removes the oldest entry |
| ovf_clr | input | 1 | Clears the overflow flag |
| head_data | output | TW (16) | Oldest stored timer value |
| not_empty | output | 1 | At least one entry is stored |
| overflow | output | 1 | Sticky flag for a discarded capture |
| cap_irq | output | 1 | One-cycle pulse per stored capture |

## Verification
A table drives each mode with a rising and a falling transition, eight cases in all. This shows that each mode bit gates only its own polarity, and that mode 00 blocks everything. During the two synchronizer cycles the timer input carries decoy values, and the real stamp appears only in the detection cycle. A capture taken one cycle early or late therefore shows up as a wrong value. Directed sequences fill the store past its depth, pop while empty, push and pop together on a full store, and toggle the pin while disabled. These separate a discard from a replacement, an ignored pop from pointer corruption, and a cleared reference from a stale one.

// File: rtl/edge_capture_fifo.sv
module edge_capture_fifo #(
  parameter int TW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_async,
  input  logic [TW-1:0] timer_val,
  input  logic [1:0]    edge_mode,
  input  logic          enable,
  input  logic          rd_pop,
  input  logic          ovf_clr,
  output logic [TW-1:0] head_data,
  output logic          not_empty,
  output logic          overflow,
  output logic          cap_irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    sync_q;
  logic          prev_q, hist_q;
  logic [TW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          ovf_q, irq_q;

  wire rise    = hist_q & sync_q[1] & ~prev_q;
  wire fall    = hist_q & ~sync_q[1] & prev_q;
  wire hit     = enable & ((edge_mode[0] & rise) | (edge_mode[1] & fall));
  wire full    = (count == CW'(DEPTH));
  wire do_pop  = enable & rd_pop & (count != '0);
  wire do_push = hit & (~full | do_pop);
  wire drop    = hit & full & ~do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], pin_async};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      prev_q <= sync_q[1];
      hist_q <= enable;
    end

  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr] <= timer_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (!enable) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= do_push;
      if (!enable)      ovf_q <= 1'b0;
      else if (drop)    ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end

  assign head_data = mem[rd_ptr];
  assign not_empty = (count != '0);
  assign overflow  = ovf_q;
  assign cap_irq   = irq_q;

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && enable && !ovf_clr) |=> ovf_q);
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && rd_pop && !hit) |=> (count == '0));
  a_r10_irq_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(enable && hit));
  a_r10_no_irq_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !irq_q);
  a_r11_disable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == '0 && !ovf_q));
endmodule

// File: tb/edge_capture_fifo_tb.sv
module edge_capture_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n, pin_async, enable, rd_pop, ovf_clr;
  logic [15:0] timer_val;
  logic [1:0]  edge_mode;
  logic [15:0] head_data;
  logic        not_empty, overflow, cap_irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_capture_fifo #(.TW(16), .DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .timer_val(timer_val),
    .edge_mode(edge_mode), .enable(enable), .rd_pop(rd_pop), .ovf_clr(ovf_clr),
    .head_data(head_data), .not_empty(not_empty), .overflow(overflow),
    .cap_irq(cap_irq));

  // {edge_mode[1:0], pin level, capture expected}
  localparam logic [3:0] VEC [0:7] = '{
    4'b01_1_1, 4'b01_0_0, 4'b10_1_0, 4'b10_0_1,
    4'b11_1_1, 4'b11_0_1, 4'b00_1_0, 4'b00_0_0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Level applied before P0; stamp is on timer only in the cycle before P2.
  task automatic capture(input logic lvl, input logic [15:0] stamp, input logic pop_now);
    @(negedge clk); pin_async = lvl; timer_val = 16'hDEAD;
    @(negedge clk); timer_val = 16'hBEEF;
    @(negedge clk); timer_val = stamp; rd_pop = pop_now;
    @(negedge clk); timer_val = 16'h0BAD; rd_pop = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b01: return "R2";
      2'b10: return "R3";
      2'b11: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_async = 1'b0; enable = 1'b0; rd_pop = 1'b0;
    ovf_clr = 1'b0; timer_val = '0; edge_mode = 2'b00;
    repeat (3) @(negedge clk);
    check("R12 not_empty", not_empty, 0);
    check("R12 overflow", overflow, 0);
    check("R12 cap_irq", cap_irq, 0);
    rst_n = 1'b1; enable = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      edge_mode = VEC[i][3:2];
      capture(VEC[i][1], 16'h1000 + 16'(i), 1'b0);
      check({mode_req(VEC[i][3:2]), " irq"}, cap_irq, VEC[i][0]);
      check({mode_req(VEC[i][3:2]), " not_empty"}, not_empty, VEC[i][0]);
      if (VEC[i][0]) check("R1/R6 stamp", head_data, 16'h1000 + 16'(i));
      @(negedge clk);
      check("R10 single pulse", cap_irq, 0);
      if (VEC[i][0]) begin
        pop();
        check("R6 drained", not_empty, 0);
      end
    end

    // R7 overflow and R8 sticky flag
    edge_mode = 2'b11;
    for (int k = 0; k < 4; k++) begin
      capture(k[0] ? 1'b0 : 1'b1, 16'hA000 + 16'(k), 1'b0);
      check("R10 irq on push", cap_irq, 1);
    end
    capture(1'b1, 16'hA004, 1'b0);
    check("R10 no irq on drop", cap_irq, 0);
    check("R7 overflow set", overflow, 1);
    check("R7 head unchanged", head_data, 16'hA000);
    for (int k = 0; k < 4; k++) begin
      check("R6 order", head_data, 16'hA000 + 16'(k));
      pop();
    end
    check("R7 depth", not_empty, 0);
    check("R8 sticky", overflow, 1);
    pop();
    check("R9 empty pop", not_empty, 0);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R8 cleared", overflow, 0);
    capture(1'b0, 16'hB000, 1'b0);
    check("R9 pointers intact", head_data, 16'hB000);
    pop();

    // R9 push and pop together on a full store
    for (int k = 0; k < 4; k++) capture(k[0] ? 1'b0 : 1'b1, 16'hC000 + 16'(k), 1'b0);
    capture(1'b1, 16'hC004, 1'b1);
    check("R9 irq on full push+pop", cap_irq, 1);
    check("R9 no overflow", overflow, 0);
    for (int k = 1; k < 5; k++) begin
      check("R9 contents", head_data, 16'hC000 + 16'(k));
      pop();
    end
    check("R9 drained", not_empty, 0);

    // R11 disable flushes and resets the reference
    for (int k = 0; k < 5; k++) capture(k[0] ? 1'b1 : 1'b0, 16'hD000 + 16'(k), 1'b0);
    check("R11 setup overflow", overflow, 1);
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R11 flushed", not_empty, 0);
    check("R11 overflow cleared", overflow, 0);
    pin_async = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11 no capture disabled", cap_irq, 0);
    end
    enable = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11 no stale edge", cap_irq, 0);
    end
    check("R11 still empty", not_empty, 0);
    capture(1'b0, 16'hD100, 1'b0);
    check("R11 rearmed", cap_irq, 1);
    check("R11 rearmed stamp", head_data, 16'hD100);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule